// File: doc/BRIEF.md
# DRAM Bank Command Timing Checker

This block sits between a memory controller's command scheduler and the DRAM pins of one channel. The channel has a single rank of four banks on a wide single-data-rate bus clocked at 5 ns. The scheduler presents one candidate command each cycle, either an activate, read, write or precharge, together with a bank number. The block answers in the same cycle whether that command may go out now. When the candidate is valid and legal, the command counts as issued, and the block updates its per-bank state and its shared timers.

The block tracks the open-row or idle state of every bank, the activate-to-column and precharge-to-activate delays of each bank, and the spacing of column commands so that 4-clock bursts never overlap on the data bus. It also enforces the write-to-read turnaround and a rolling window that allows only two activates in any ten cycles. For reads it produces a one-cycle marker in the cycle the first data beat is due. All delays are held in cycles, derived from nanosecond values and the clock period.

Top module: `dram_cmd_guard`

## Requirements
- R1: After synchronous active-high reset every bank is idle (`bank_open` = 0), an activate to any bank is legal, and `rd_data_start` is low.
- R2: Operation codes on `cmd_op` are 0 activate, 1 read, 2 write and 3 precharge. An activate is legal only to an idle bank, and read, write and precharge only to a bank with an open row. Bit b of `bank_open` goes high after an issued activate to bank b and low after an issued precharge to bank b.
- R3: A read or write to a bank is legal no sooner than 4 cycles after the activate to that bank was issued.
- R4: An activate to a bank is legal no sooner than 4 cycles after the precharge to that bank was issued.
- R5: Two column commands (read or write, to any banks) are at least 4 cycles apart, which is the length of one burst.
- R6: A read is legal no sooner than 7 cycles after the last write was issued (4 burst cycles plus a 3-cycle turnaround).
- R7: At most two activates fall in any 10-cycle window. A third activate is legal only once 10 or more cycles have passed since the older of the two previous ones.
- R8: `rd_data_start` is high for exactly one cycle, 4 cycles after a read was issued, and is low at all other times.
- R9: A command presented with `cmd_valid` low is not issued. It changes neither `bank_open` nor any timer, although `cmd_ready` still reports its legality.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 5 ns nominal |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Candidate command is to be issued if legal |
| cmd_op | input | 2 | Operation: 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | 2 | Target bank |
| cmd_ready | output | 1 | The presented command is legal this cycle |
| bank_open | output | 4 | One bit per bank, high while its row is open |
| rd_data_start | output | 1 | First read data beat is due this cycle |

## Verification
Directed segments hold one command on the port and step it cycle by cycle across each delay boundary. Examples are a read held after an activate, an activate held after a precharge, a third activate pushed against the two-activate window, and a read placed after a write. These separate an off-by-one in each timer from a wrong reference event. Commands presented with valid low show whether legality is reported without any state change. A long pseudo-random stream of mixed operations and banks is then compared each cycle against a timestamp model. This stream brings out the interactions between the per-bank timers and the shared bus and window timers that the directed cases do not reach.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    localparam int NUM_BANKS = 4;
    localparam int CLK_PS    = 5000;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    function automatic int ps_to_cyc(int ps, int clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int T_RCD_CYC   = ps_to_cyc(18000, CLK_PS);
    localparam int T_RP_CYC    = ps_to_cyc(18000, CLK_PS);
    localparam int T_CL_CYC    = ps_to_cyc(18000, CLK_PS);
    localparam int T_BURST_CYC = ps_to_cyc(20000, CLK_PS);
    localparam int T_WTR_CYC   = max_int(2, ps_to_cyc(15000, CLK_PS));
    localparam int ACT_WIN_CYC = ps_to_cyc(50000, CLK_PS);
    localparam int ACT_LIMIT   = 2;

endpackage

// File: rtl/dcg_bank.sv
module dcg_bank
    import dcg_pkg::*;
#(
    parameter int T_RCD = T_RCD_CYC,
    parameter int T_RP  = T_RP_CYC,
    localparam int TW   = $clog2(max_int(T_RCD, T_RP) + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    input  cmd_e op_i,
    output logic open_o,
    output logic ready_o
);

    logic          open_q;
    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            tmr_q  <= '0;
        end else begin
            if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
            if (sel_i) begin
                case (op_i)
                    CMD_ACT: begin
                        open_q <= 1'b1;
                        tmr_q  <= TW'(T_RCD - 1);
                    end
                    CMD_PRE: begin
                        open_q <= 1'b0;
                        tmr_q  <= TW'(T_RP - 1);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign open_o  = open_q;
    assign ready_o = (tmr_q == '0);

    // R2
    bank_open_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(open_q) |-> $past(sel_i && op_i == CMD_ACT));

    // R3 R4
    bank_tmr_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_i && op_i != CMD_PRE) |-> tmr_q == '0);

endmodule

// File: rtl/dcg_act_window.sv
module dcg_act_window
    import dcg_pkg::*;
#(
    parameter int ACT_WIN = ACT_WIN_CYC,
    parameter int LIMIT   = ACT_LIMIT,
    localparam int WW     = $clog2(ACT_WIN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    output logic ok_o
);

    logic [WW-1:0]    slot_q [LIMIT];
    logic [LIMIT-1:0] free;
    logic [LIMIT-1:0] pick;
    logic [LIMIT-1:0] fresh;

    always_comb begin
        logic taken;
        taken = 1'b0;
        pick  = '0;
        for (int i = 0; i < LIMIT; i++) begin
            if (free[i] && !taken) begin
                pick[i] = 1'b1;
                taken   = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < LIMIT; i++) begin : g_slot
        assign free[i]  = (slot_q[i] == '0);
        assign fresh[i] = (slot_q[i] == WW'(ACT_WIN - 1));
        always_ff @(posedge clk) begin
            if (rst)                  slot_q[i] <= '0;
            else if (act_i && pick[i]) slot_q[i] <= WW'(ACT_WIN - 1);
            else if (!free[i])        slot_q[i] <= slot_q[i] - 1'b1;
        end
    end

    assign ok_o = |free;

    // R7
    win_free_chk: assert property (@(posedge clk) disable iff (rst)
        act_i |-> ok_o);

    // R7
    win_load_chk: assert property (@(posedge clk) disable iff (rst)
        act_i |=> $countones(fresh) == 1);

endmodule

// File: rtl/dcg_col_bus.sv
module dcg_col_bus
    import dcg_pkg::*;
#(
    parameter int T_BURST = T_BURST_CYC,
    parameter int T_WTR   = T_WTR_CYC,
    parameter int T_CL    = T_CL_CYC,
    localparam int T_W2R  = T_BURST + T_WTR,
    localparam int CW     = $clog2(T_W2R + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_i,
    input  logic wr_i,
    output logic col_ok_o,
    output logic rd_ok_o,
    output logic rd_data_o
);

    logic [CW-1:0]   col_q;
    logic [CW-1:0]   w2r_q;
    logic [T_CL-1:0] rd_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            w2r_q <= '0;
        end else begin
            if (rd_i || wr_i)      col_q <= CW'(T_BURST - 1);
            else if (col_q != '0) col_q <= col_q - 1'b1;
            if (wr_i)              w2r_q <= CW'(T_W2R - 1);
            else if (w2r_q != '0) w2r_q <= w2r_q - 1'b1;
        end
    end

    if (T_CL == 1) begin : g_cl_one
        always_ff @(posedge clk) begin
            if (rst) rd_pipe <= '0;
            else     rd_pipe <= rd_i;
        end
    end else begin : g_cl_shift
        always_ff @(posedge clk) begin
            if (rst) rd_pipe <= '0;
            else     rd_pipe <= {rd_pipe[T_CL-2:0], rd_i};
        end
    end

    assign col_ok_o  = (col_q == '0);
    assign rd_ok_o   = (w2r_q == '0);
    assign rd_data_o = rd_pipe[T_CL-1];

    // R5
    col_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i || wr_i) |-> col_q == '0);

    // R5
    col_single_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_i && wr_i));

    // R6
    rd_turn_chk: assert property (@(posedge clk) disable iff (rst)
        rd_i |-> w2r_q == '0);

    if (T_BURST >= T_CL) begin : g_pipe_chk
        // R8
        rd_pipe_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(rd_pipe));
    end

endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard
    import dcg_pkg::*;
#(
    parameter int NB        = NUM_BANKS,
    parameter int T_RCD     = T_RCD_CYC,
    parameter int T_RP      = T_RP_CYC,
    parameter int T_CL      = T_CL_CYC,
    parameter int T_BURST   = T_BURST_CYC,
    parameter int T_WTR     = T_WTR_CYC,
    parameter int ACT_WIN   = ACT_WIN_CYC,
    parameter int ACT_LIM   = ACT_LIMIT,
    localparam int BW       = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [BW-1:0] cmd_bank,
    output logic          cmd_ready,
    output logic [NB-1:0] bank_open,
    output logic          rd_data_start
);

    cmd_e          op;
    logic          issue;
    logic [NB-1:0] bank_rdy;
    logic [NB-1:0] bank_sel;
    logic          win_ok;
    logic          col_ok;
    logic          rd_ok;
    logic          in_range;
    logic          tgt_open;
    logic          tgt_rdy;

    assign op       = cmd_e'(cmd_op);
    assign in_range = (32'(cmd_bank) < NB);
    assign tgt_open = in_range && bank_open[cmd_bank];
    assign tgt_rdy  = in_range && bank_rdy[cmd_bank];
    assign issue    = cmd_valid && cmd_ready;

    always_comb begin
        case (op)
            CMD_ACT: cmd_ready = in_range && !tgt_open && tgt_rdy && win_ok;
            CMD_RD:  cmd_ready = tgt_open && tgt_rdy && col_ok && rd_ok;
            CMD_WR:  cmd_ready = tgt_open && tgt_rdy && col_ok;
            default: cmd_ready = tgt_open;
        endcase
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_sel[b] = issue && (32'(cmd_bank) == b);
        dcg_bank #(.T_RCD(T_RCD), .T_RP(T_RP)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .sel_i  (bank_sel[b]),
            .op_i   (op),
            .open_o (bank_open[b]),
            .ready_o(bank_rdy[b])
        );
    end

    dcg_act_window #(.ACT_WIN(ACT_WIN), .LIMIT(ACT_LIM)) u_win (
        .clk  (clk),
        .rst  (rst),
        .act_i(issue && op == CMD_ACT),
        .ok_o (win_ok)
    );

    dcg_col_bus #(.T_BURST(T_BURST), .T_WTR(T_WTR), .T_CL(T_CL)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .rd_i     (issue && op == CMD_RD),
        .wr_i     (issue && op == CMD_WR),
        .col_ok_o (col_ok),
        .rd_ok_o  (rd_ok),
        .rd_data_o(rd_data_start)
    );

    // R2
    top_idle_col_chk: assert property (@(posedge clk) disable iff (rst)
        (op != CMD_ACT && !tgt_open) |-> !cmd_ready);

    // R2
    top_open_act_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CMD_ACT && tgt_open) |-> !cmd_ready);

    // R9
    top_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(bank_open));

endmodule

// File: tb/sim_dram_cmd_guard.sv
module sim_dram_cmd_guard;
    import dcg_pkg::*;

    localparam int NB = NUM_BANKS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_ready;
    logic [3:0] bank_open;
    logic       rd_data_start;

    always #4 clk = ~clk;

    dram_cmd_guard u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ready(cmd_ready), .bank_open(bank_open),
        .rd_data_start(rd_data_start)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int cyc = 0;
    int last_act [NB];
    int last_pre [NB];
    bit open_m   [NB];
    int last_col, last_wr, last_rd, act_old, act_new;

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    function automatic bit model_ready(logic [1:0] op, int b);
        case (op)
            2'd0: return !open_m[b] && (cyc - last_pre[b] >= T_RP_CYC)
                         && (cyc - act_old >= ACT_WIN_CYC);
            2'd1: return open_m[b] && (cyc - last_act[b] >= T_RCD_CYC)
                         && (cyc - last_col >= T_BURST_CYC)
                         && (cyc - last_wr >= T_BURST_CYC + T_WTR_CYC);
            2'd2: return open_m[b] && (cyc - last_act[b] >= T_RCD_CYC)
                         && (cyc - last_col >= T_BURST_CYC);
            default: return open_m[b];
        endcase
    endfunction

    function automatic logic [3:0] model_open();
        logic [3:0] v;
        for (int i = 0; i < NB; i++) v[i] = open_m[i];
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin
            last_act[i] = -1000; last_pre[i] = -1000; open_m[i] = 0;
        end
        last_col = -1000; last_wr = -1000; last_rd = -1000;
        act_old = -1000; act_new = -1000;
    endtask

    task automatic tick(bit v, logic [1:0] op, int b, string tag);
        bit exp;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_bank = b[1:0];
        #1;
        exp = model_ready(op, b);
        check(tag, {3'b0, cmd_ready}, {3'b0, exp});
        check("R8", {3'b0, rd_data_start}, {3'b0, (last_rd + T_CL_CYC == cyc)});
        check("R2/R9 bank_open", bank_open, model_open());
        @(posedge clk);
        if (v && exp) begin
            case (op)
                2'd0: begin open_m[b] = 1; last_act[b] = cyc; act_old = act_new; act_new = cyc; end
                2'd1: begin last_col = cyc; last_rd = cyc; end
                2'd2: begin last_col = cyc; last_wr = cyc; end
                default: begin open_m[b] = 0; last_pre[b] = cyc; end
            endcase
        end
        cyc++;
    endtask

    function automatic string op_tag(logic [1:0] op);
        case (op)
            2'd0: return "R4/R7 act";
            2'd1: return "R3/R5/R6 rd";
            2'd2: return "R3/R5 wr";
            default: return "R2 pre";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 bank_open", bank_open, 4'h0);
        check("R1 rd_data_start", {3'b0, rd_data_start}, 4'h0);
        for (int b = 0; b < NB; b++) begin
            cmd_op = 2'd0; cmd_bank = b[1:0]; #1;
            check("R1 act ready", {3'b0, cmd_ready}, 4'h1);
        end

        // R2: column and precharge to idle bank refused
        tick(1, 2'd1, 0, "R2 rd idle");
        tick(1, 2'd2, 0, "R2 wr idle");
        tick(1, 2'd3, 0, "R2 pre idle");
        // R2/R3: activate, then hold read until legal
        tick(1, 2'd0, 0, "R2 act");
        tick(1, 2'd0, 0, "R2 act open");
        tick(1, 2'd0, 1, "R7 second act");
        for (int k = 0; k < 6; k++) tick(1, 2'd1, 0, "R3 rd after act");
        // R7: third activate pushed against window
        for (int k = 0; k < 10; k++) tick(1, 2'd0, 2, "R7 third act");
        // R5: write held against burst spacing
        for (int k = 0; k < 6; k++) tick(1, 2'd2, 1, "R5 wr gap");
        // R6: read after write
        for (int k = 0; k < 10; k++) tick(1, 2'd1, 2, "R6 rd after wr");
        // R4: precharge then re-activate same bank
        tick(1, 2'd3, 0, "R2 pre");
        for (int k = 0; k < 12; k++) tick(1, 2'd0, 0, "R4 act after pre");
        // R9: commands without valid leave state unchanged
        for (int k = 0; k < 4; k++) tick(0, 2'd3, k, "R9 no issue pre");
        for (int k = 0; k < 4; k++) tick(0, 2'd0, 3, "R9 no issue act");
        // R8: idle until any read data marker drains
        for (int k = 0; k < 8; k++) tick(0, 2'd1, 3, "R8 drain");

        // Pseudo-random sweep against the timestamp model
        lfsr = 16'hACE1;
        for (int k = 0; k < 6000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick(lfsr[0] | lfsr[1], lfsr[3:2], int'(lfsr[5:4]), op_tag(lfsr[3:2]));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule